// File: doc/BRIEF.md
# Two-Port Pipelined Word Memory with Cross-Port Pass-Through

This block is a synchronous word memory with two independent ports, X and Y, that share one array. In every enabled cycle each port can read a word, write a word, or forward its own write data to the opposite port's output. The same cycle can also mix these operations across the two ports. Every command input is captured on the rising clock edge. Read data and passed data then go through a per-port output register. Each port's output enable is combinational and gates only the drive flag that port presents to an external bidirectional pad. The pad itself lies outside the block, so each bus appears here as a separate input word, output word and drive flag.

The array has 2^ADDR_W words of DATA_W bits. Setting ADDR_W=15 and DATA_W=36 gives the full 32768 x 36 configuration. The elaboration default keeps ADDR_W smaller so the array stays modest. Fixed rules settle collisions between the two ports. A read always sees the array contents from before any write in the same cycle. When both ports write the same word, the Y data is the one stored. Tying the two address buses together gives a memory with a single address.

The ports carry no handshake. The memory accepts a command on every enabled clock, so there is no back-pressure. A reader must sample a result exactly two edges after it presents the command.

Top module: `dpsr_pt_top`

## Requirements
- R1: While rst_n is low, x_drive, y_drive, x_dout and y_dout are all 0.
- R2: A read presented before clock edge k appears on that port's dout after edge k+1, and the port's drive flag is then 1 when its oe is 1.
- R3: oe acts without a clock: when x_oe (or y_oe) is 0, x_drive (or y_drive) is 0 in the same cycle, and it returns to its registered value when oe goes back to 1.
- R4: A cycle is enabled only when cs_a and cs_b are both 1. In any other cycle nothing is written and dout and drive of both ports keep their previous values.
- R5: With x_pass=1 in an enabled cycle, y_dout shows the x_din of that cycle two edges later, in place of the Y array read.
- R6: With y_pass=1 in an enabled cycle, x_dout shows the y_din of that cycle two edges later, in place of the X array read.
- R7: When both ports read the same address in one cycle, both return the stored word.
- R8: When one port writes an address and the other port reads that same address in the same cycle, the reader gets the contents from before the write, and the new word is stored.
- R9: When both ports write the same address in one cycle, the word stored is y_din.
- R10: A port that presents a write (we=1) in an enabled cycle has its drive flag at 0 for the output cycle that follows.
- R11: With x_addr and y_addr tied to the same value, a word written on one port is read back on either port in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_a | input | 1 | First chip select, registered |
| cs_b | input | 1 | Second chip select, registered |
| x_addr | input | ADDR_W | Port X word address |
| x_we | input | 1 | Port X write enable |
| x_pass | input | 1 | Forward x_din to port Y output |
| x_din | input | DATA_W | Port X write data |
| x_oe | input | 1 | Port X asynchronous output enable |
| x_dout | output | DATA_W | Port X registered output word |
| x_drive | output | 1 | Port X pad drive flag |
| y_addr | input | ADDR_W | Port Y word address |
| y_we | input | 1 | Port Y write enable |
| y_pass | input | 1 | Forward y_din to port X output |
| y_din | input | DATA_W | Port Y write data |
| y_oe | input | 1 | Port Y asynchronous output enable |
| y_dout | output | DATA_W | Port Y registered output word |
| y_drive | output | 1 | Port Y pad drive flag |

## Verification
The read and write paths are tried with distinct addresses on the two ports and with cross reads of words written through the other port. These patterns show whether the two ports truly share one array with independent decoders. Same-address patterns cover read/read, write/read and write/write, and together they separate read-before-write ordering and Y priority from their inverses. Pass-through is applied in each direction while the target port also reads, which shows both the routing and its precedence over the array. Deselect through each chip select alone, together with oe toggled between clocks, shows that enable gating and output gating are separate.

// File: rtl/dpsr_pkg.sv
package dpsr_pkg;
  // Port indices; the higher index wins a same-address write.
  localparam int unsigned PORT_X = 0;
  localparam int unsigned PORT_Y = 1;
  localparam int unsigned NPORT  = 2;

  // Source selected into a port's output register.
  typedef enum logic {
    SRC_ARRAY = 1'b0,
    SRC_PASS  = 1'b1
  } out_src_e;
endpackage

// File: rtl/dpsr_in_stage.sv
module dpsr_in_stage #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              pass_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              we_q,
  output logic              pass_q,
  output logic [DATA_W-1:0] din_q
);
  // Control bits are reset; address and data are plain pipeline flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      we_q   <= we_i;
      pass_q <= pass_i;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_i;
    din_q  <= din_i;
  end
endmodule

// File: rtl/dpsr_array.sv
module dpsr_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 36,
  parameter int unsigned NP     = 2
) (
  input  logic                       clk,
  input  logic                       en,
  input  logic [NP-1:0]              we,
  input  logic [NP-1:0][ADDR_W-1:0]  addr,
  input  logic [NP-1:0][DATA_W-1:0]  wdata,
  output logic [NP-1:0][DATA_W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Combinational read of the current contents; the write below lands at the
  // same edge that loads the output registers, so readers see old data.
  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rdata[p] = mem[addr[p]];
  end

  // Ascending port order: the last port written (Y) wins a same-word clash.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (en && we[p]) mem[addr[p]] <= wdata[p];
    end
  end
endmodule

// File: rtl/dpsr_out_stage.sv
module dpsr_out_stage
  import dpsr_pkg::*;
#(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic              pass_in,
  input  logic [DATA_W-1:0] pass_data,
  input  logic [DATA_W-1:0] rdata,
  input  logic              oe,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);
  out_src_e          src;
  logic [DATA_W-1:0] dout_q;
  logic              drv_q;

  assign src = pass_in ? SRC_PASS : SRC_ARRAY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      drv_q  <= 1'b0;
    end else if (en) begin
      dout_q <= (src == SRC_PASS) ? pass_data : rdata;
      drv_q  <= !we;
    end
  end

  assign dout  = dout_q;
  assign drive = drv_q & oe;
endmodule

// File: rtl/dpsr_pt_top.sv
module dpsr_pt_top
  import dpsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic              x_we,
  input  logic              x_pass,
  input  logic [DATA_W-1:0] x_din,
  input  logic              x_oe,
  output logic [DATA_W-1:0] x_dout,
  output logic              x_drive,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic              y_we,
  input  logic              y_pass,
  input  logic [DATA_W-1:0] y_din,
  input  logic              y_oe,
  output logic [DATA_W-1:0] y_dout,
  output logic              y_drive
);
  logic [NPORT-1:0][ADDR_W-1:0] addr_i, addr_q;
  logic [NPORT-1:0]             we_i, we_q, pass_i, pass_q, oe_i, drv_o;
  logic [NPORT-1:0][DATA_W-1:0] din_i, din_q, rdata, dout_o;
  logic                         en_q;

  assign addr_i = {y_addr, x_addr};
  assign we_i   = {y_we, x_we};
  assign pass_i = {y_pass, x_pass};
  assign din_i  = {y_din, x_din};
  assign oe_i   = {y_oe, x_oe};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= cs_a & cs_b;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int unsigned OTHER = NPORT - 1 - p;

    dpsr_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (addr_i[p]),
      .we_i   (we_i[p]),
      .pass_i (pass_i[p]),
      .din_i  (din_i[p]),
      .addr_q (addr_q[p]),
      .we_q   (we_q[p]),
      .pass_q (pass_q[p]),
      .din_q  (din_q[p])
    );

    // Output of port p takes pass data from the opposite port.
    dpsr_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .we        (we_q[p]),
      .pass_in   (pass_q[OTHER]),
      .pass_data (din_q[OTHER]),
      .rdata     (rdata[p]),
      .oe        (oe_i[p]),
      .dout      (dout_o[p]),
      .drive     (drv_o[p])
    );
  end

  dpsr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NP(NPORT)) u_mem (
    .clk   (clk),
    .en    (en_q),
    .we    (we_q),
    .addr  (addr_q),
    .wdata (din_q),
    .rdata (rdata)
  );

  assign x_dout  = dout_o[PORT_X];
  assign y_dout  = dout_o[PORT_Y];
  assign x_drive = drv_o[PORT_X];
  assign y_drive = drv_o[PORT_Y];
endmodule

// File: rtl/dpsr_pt_chk.sv
module dpsr_pt_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_a,
  input logic              cs_b,
  input logic [ADDR_W-1:0] x_addr,
  input logic              x_we,
  input logic              x_pass,
  input logic [DATA_W-1:0] x_din,
  input logic              x_oe,
  input logic [DATA_W-1:0] x_dout,
  input logic              x_drive,
  input logic [ADDR_W-1:0] y_addr,
  input logic              y_we,
  input logic              y_pass,
  input logic [DATA_W-1:0] y_din,
  input logic              y_oe,
  input logic [DATA_W-1:0] y_dout,
  input logic              y_drive
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!x_drive && !y_drive && x_dout == '0 && y_dout == '0);
    end
  end

  always_comb begin
    if (!x_oe) assert_x_oe_gate_R3: assert (!x_drive);
    if (!y_oe) assert_y_oe_gate_R3: assert (!y_drive);
  end

  assert_deselect_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_a && cs_b) |=> ##1 ($stable(x_dout) && $stable(y_dout)));

  assert_xpass_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a && cs_b && x_pass) |=> ##1 (y_dout == $past(x_din, 2)));

  assert_ypass_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a && cs_b && y_pass) |=> ##1 (x_dout == $past(y_din, 2)));

  assert_x_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a && cs_b && x_we) |=> ##1 !x_drive);

  assert_y_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a && cs_b && y_we) |=> ##1 !y_drive);
endmodule

bind dpsr_pt_top dpsr_pt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/dpsr_pt_top_tb.sv
module dpsr_pt_top_tb_top;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_a, cs_b;
  logic [AW-1:0] x_addr, y_addr;
  logic          x_we, y_we, x_pass, y_pass, x_oe, y_oe;
  logic [DW-1:0] x_din, y_din;
  logic [DW-1:0] x_dout, y_dout;
  logic          x_drive, y_drive;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dpsr_pt_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b),
    .x_addr(x_addr), .x_we(x_we), .x_pass(x_pass), .x_din(x_din),
    .x_oe(x_oe), .x_dout(x_dout), .x_drive(x_drive),
    .y_addr(y_addr), .y_we(y_we), .y_pass(y_pass), .y_din(y_din),
    .y_oe(y_oe), .y_dout(y_dout), .y_drive(y_drive)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Deselected, no write, no pass.
  task automatic idle();
    cs_a = 1'b1; cs_b = 1'b0;
    x_we = 1'b0; y_we = 1'b0; x_pass = 1'b0; y_pass = 1'b0;
  endtask

  task automatic cmd(input logic xw, input logic [AW-1:0] xa, input logic [DW-1:0] xd, input logic xp,
                     input logic yw, input logic [AW-1:0] ya, input logic [DW-1:0] yd, input logic yp);
    cs_a = 1'b1; cs_b = 1'b1;
    x_we = xw; x_addr = xa; x_din = xd; x_pass = xp;
    y_we = yw; y_addr = ya; y_din = yd; y_pass = yp;
  endtask

  // Present a command, then idle; outputs are valid after the second edge.
  task automatic issue(input logic xw, input logic [AW-1:0] xa, input logic [DW-1:0] xd, input logic xp,
                       input logic yw, input logic [AW-1:0] ya, input logic [DW-1:0] yd, input logic yp);
    cmd(xw, xa, xd, xp, yw, ya, yd, yp);
    cyc();
    idle();
    cyc();
  endtask

  task automatic t_reset();
    check("R1 x_drive", {35'd0, x_drive}, '0);
    check("R1 y_drive", {35'd0, y_drive}, '0);
    check("R1 x_dout", x_dout, '0);
    check("R1 y_dout", y_dout, '0);
  endtask

  task automatic t_basic();
    issue(1'b1, 10'd5, 36'hA_1111_2222, 1'b0, 1'b1, 10'd9, 36'hB_3333_4444, 1'b0);
    check("R10 x_drive after write", {35'd0, x_drive}, '0);
    check("R10 y_drive after write", {35'd0, y_drive}, '0);
    issue(1'b0, 10'd9, '0, 1'b0, 1'b0, 10'd5, '0, 1'b0);
    check("R2 x reads Y-written word", x_dout, 36'hB_3333_4444);
    check("R2 y reads X-written word", y_dout, 36'hA_1111_2222);
    check("R2 x_drive", {35'd0, x_drive}, 36'd1);
  endtask

  task automatic t_oe();
    x_oe = 1'b0; #1;
    check("R3 x_oe low gates drive", {35'd0, x_drive}, '0);
    check("R3 y unaffected", {35'd0, y_drive}, 36'd1);
    x_oe = 1'b1; #1;
    check("R3 x_oe high restores drive", {35'd0, x_drive}, 36'd1);
  endtask

  task automatic t_deselect();
    cmd(1'b1, 10'd5, 36'hC_DEAD_BEEF, 1'b0, 1'b0, 10'd9, '0, 1'b0);
    cs_b = 1'b0;
    cyc(); idle(); cyc();
    check("R4 x_dout held (cs_b low)", x_dout, 36'hB_3333_4444);
    cmd(1'b0, 10'd9, '0, 1'b0, 1'b1, 10'd5, 36'hC_0BAD_F00D, 1'b0);
    cs_a = 1'b0;
    cyc(); idle(); cyc();
    check("R4 y_drive held (cs_a low)", {35'd0, y_drive}, 36'd1);
    issue(1'b0, 10'd5, '0, 1'b0, 1'b0, 10'd5, '0, 1'b0);
    check("R4 no write when deselected", x_dout, 36'hA_1111_2222);
  endtask

  task automatic t_pass();
    issue(1'b0, 10'd5, 36'hD_5555_6666, 1'b1, 1'b0, 10'd9, 36'hE_7777_8888, 1'b0);
    check("R5 y shows x_din", y_dout, 36'hD_5555_6666);
    check("R5 x still reads array", x_dout, 36'hA_1111_2222);
    issue(1'b0, 10'd5, 36'h1_0000_0001, 1'b0, 1'b0, 10'd9, 36'hF_9999_0000, 1'b1);
    check("R6 x shows y_din", x_dout, 36'hF_9999_0000);
    check("R6 y still reads array", y_dout, 36'hB_3333_4444);
  endtask

  task automatic t_collide();
    issue(1'b0, 10'd5, '0, 1'b0, 1'b0, 10'd5, '0, 1'b0);
    check("R7 x same-address read", x_dout, 36'hA_1111_2222);
    check("R7 y same-address read", y_dout, 36'hA_1111_2222);
    issue(1'b1, 10'd9, 36'h2_2222_2222, 1'b0, 1'b0, 10'd9, '0, 1'b0);
    check("R8 reader sees old word", y_dout, 36'hB_3333_4444);
    issue(1'b0, 10'd9, '0, 1'b0, 1'b0, 10'd9, '0, 1'b0);
    check("R8 new word stored", y_dout, 36'h2_2222_2222);
    issue(1'b1, 10'd11, 36'h3_3333_3333, 1'b0, 1'b1, 10'd11, 36'h4_4444_4444, 1'b0);
    issue(1'b0, 10'd11, '0, 1'b0, 1'b0, 10'd11, '0, 1'b0);
    check("R9 Y data wins", x_dout, 36'h4_4444_4444);
  endtask

  task automatic t_tied();
    issue(1'b0, 10'd20, '0, 1'b0, 1'b1, 10'd20, 36'h5_1234_5678, 1'b0);
    check("R11 tied: x read in write cycle old", x_dout != 36'h5_1234_5678 ? 36'd1 : 36'd0, 36'd1);
    issue(1'b0, 10'd20, '0, 1'b0, 1'b0, 10'd20, '0, 1'b0);
    check("R11 tied: x reads Y write", x_dout, 36'h5_1234_5678);
    check("R11 tied: y reads own write", y_dout, 36'h5_1234_5678);
  endtask

  initial begin
    idle();
    x_addr = '0; y_addr = '0; x_din = '0; y_din = '0;
    x_oe = 1'b1; y_oe = 1'b1;
    repeat (3) cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_basic();
    t_oe();
    t_deselect();
    t_pass();
    t_collide();
    t_tied();
    repeat (2) cyc();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule